// File: doc/BRIEF.md
# TLB Management Register Interface

This block lets software maintain a table of address-translation entries through a small register bus. Each entry holds a tag word (virtual page number, page size, valid), a data word (physical page number, access bits, zone select) and an 8-bit translation ID. An index register selects the entry that the low-word and high-word ports read or write. A process ID register supplies the translation ID that is stamped on an entry when its tag is written. Reading a tag copies that entry's translation ID back into the process ID register.

A write to the search register starts a lookup of the written address. The lookup is a read access in the current privilege mode, and it follows the same match, translation-ID and zone rules that a translation would use. After a fixed two cycles the result goes into the index register. On a hit the index register takes the matching entry number. On a miss it keeps its old value with bit 31 set.

Two static configuration inputs gate access. One gives the level of MMU support and the other is a 2-bit access level. Together they decide which registers can be read or written. Bus accesses use a write strobe and a read strobe. A read strobe is needed because reading the tag word has a side effect.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset, the index, process ID and zone registers read 0. Every entry is invalid, so a search misses, and both entry words of entry 0 read 0.
- R2: The register numbers are index = 0, low (data) word = 1, high (tag) word = 2, process ID = 3, zone = 4 and search = 5. The low log2(ENTRIES) bits of the index register select the entry. A word written through the low or high port reads back unchanged from the same entry.
- R3: Writing the high word stores bits [7:0] of the current process ID as that entry's translation ID.
- R4: Reading the high word loads the process ID register with the entry's translation ID, zero-extended. Reading the low word leaves the process ID unchanged.
- R5: A search hits the lowest-numbered entry that meets all of the following:
  - tag bit 6 (valid) is set;
  - the address equals the tag in bits [31:s], where s = 10 + 2·code and code is tag bits [9:7];
  - its translation ID is 0, or it equals process ID bits [7:0];
  - the zone rule of R6 does not reject it.
  On a hit, the index register becomes that entry number.
- R6: Data bits [7:4] select a zone z. Its 2-bit field is zone-register bits [31−2z : 30−2z]. A field of 0 rejects the entry for a search in user mode but not in supervisor mode. If z exceeds ZONE_LIMIT, the field counts as 1 and the entry is never rejected.
- R7: A search miss sets bit 31 of the index register and keeps its other bits.
- R8: After a search write, busy is high for exactly two cycles. The index register shows the result once busy falls. While busy is high, writes have no effect and reads return 0.
- R9: If the MMU level is below 2 or the access level is 0, every register reads 0 and every write is ignored.
- R10: If bit 1 of the access level is clear, writes to the process ID, zone and search registers are ignored. Writes to the index, low and high registers still take effect.
- R11: If bit 0 of the access level is clear, reads of the low, high, process ID and zone registers return 0 and the high-word read has no side effect. The index register stays readable.
- R12: The search register and the unassigned numbers 6 and 7 read 0. Writes to 6 and 7 change nothing.

A process ID write that equals the current value leaves the register as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mmu_level | input | 2 | MMU support level; 2 or more enables the registers |
| cfg_access | input | 2 | Access level: bit 0 allows entry/ID/zone reads, bit 1 allows ID/zone/search writes |
| user_mode | input | 1 | Current mode for searches (1 = user) |
| reg_num | input | 3 | Register number |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (applies read side effects) |
| reg_rdata | output | 32 | Read data for reg_num, same cycle |
| busy | output | 1 | Search in progress; accesses are ignored |

## Verification
Directed searches separate the match rules one at a time:
- two valid entries on one address show lowest-index priority;
- a 16 MB entry matched by an address that differs in low bits shows the size-dependent compare;
- an entry stamped with a foreign translation ID shows the ID filter;
- one entry probed in user and supervisor mode, with zone fields of 0 and with an out-of-range zone select, shows the zone rule.

Seeded random phases mix entry writes, process ID and zone changes with searches over a narrow address pool, so that hits and misses both occur often. A reference model in the bench predicts each result. The gating cases change one configuration bit at a time and read back through a fully enabled configuration, to show that a blocked write left no trace.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

    typedef enum logic [2:0] {
        RN_INDEX  = 3'd0,
        RN_LO     = 3'd1,
        RN_HI     = 3'd2,
        RN_PID    = 3'd3,
        RN_ZONE   = 3'd4,
        RN_SEARCH = 3'd5
    } reg_num_e;

    // Tag word layout: page number, size code, valid flag.
    typedef struct packed {
        logic [21:0] epn;
        logic [2:0]  size;
        logic        valid;
        logic [5:0]  rsvd;
    } tag_word_t;

    // Data word layout: physical page, exec, write, zone select.
    typedef struct packed {
        logic [21:0] rpn;
        logic        ex;
        logic        wr;
        logic [3:0]  zsel;
        logic [3:0]  rsvd;
    } data_word_t;

    typedef enum logic [1:0] {
        SR_IDLE   = 2'd0,
        SR_EVAL   = 2'd1,
        SR_COMMIT = 2'd2
    } srch_state_e;

    localparam logic [31:0] EPN_MASK = 32'hFFFF_FC00;
    localparam int unsigned MMU_FULL_LEVEL = 2;

    // Mask of the address bits above the page offset for a size code.
    function automatic logic [31:0] page_mask(input logic [2:0] code);
        return 32'hFFFF_FFFF << (5'd10 + {1'b0, code, 1'b0});
    endfunction

    // Two-bit protection field of a zone; zone 0 sits in the top bits.
    function automatic logic [1:0] zone_field(input logic [31:0] zreg,
                                              input logic [3:0]  zsel);
        logic [31:0] shifted;
        shifted = zreg >> (5'd30 - {zsel, 1'b0});
        return shifted[1:0];
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] sel,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [31:0]      wdata,
    input  logic [7:0]       tid_in,
    output logic [31:0]      sel_lo,
    output logic [31:0]      sel_hi,
    output logic [7:0]       sel_tid,
    output logic [31:0]      tags_o  [ENTRIES],
    output logic [3:0]       zsels_o [ENTRIES],
    output logic [7:0]       tids_o  [ENTRIES]
);

    logic [31:0] data_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic hit_sel;
        data_word_t dw;

        assign hit_sel = (sel == IDX_W'(g));
        assign dw      = data_word_t'(data_q[g]);

        always_ff @(posedge clk) begin
            if (rst) begin
                tags_o[g] <= '0;
                data_q[g] <= '0;
                tids_o[g] <= '0;
            end else begin
                if (we_lo && hit_sel) begin
                    data_q[g] <= wdata;
                end
                if (we_hi && hit_sel) begin
                    tags_o[g] <= wdata;
                    tids_o[g] <= tid_in;
                end
            end
        end

        assign zsels_o[g] = dw.zsel;

        // R3: a tag write stamps the translation ID presented with it
        a_r3_tid_capture: assert property (@(posedge clk) disable iff (rst)
            (we_hi && hit_sel) |=> (tids_o[g] == $past(tid_in)));
    end

    assign sel_lo  = data_q[sel];
    assign sel_hi  = tags_o[sel];
    assign sel_tid = tids_o[sel];

endmodule

// File: rtl/tlb_match_engine.sv
module tlb_match_engine
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int ZONE_LIMIT = 7,
    parameter int IDX_W      = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      vaddr,
    input  logic             user,
    input  logic [7:0]       pid8,
    input  logic [31:0]      zone_reg,
    input  logic [31:0]      tags  [ENTRIES],
    input  logic [3:0]       zsels [ENTRIES],
    input  logic [7:0]       tids  [ENTRIES],
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);

    localparam logic [3:0] ZLIM = ZONE_LIMIT[3:0];

    logic [ENTRIES-1:0] cand;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        tag_word_t  tw;
        logic       addr_ok;
        logic       tid_ok;
        logic [1:0] zf;

        assign tw      = tag_word_t'(tags[g]);
        assign addr_ok = ((vaddr ^ tags[g]) & page_mask(tw.size)) == 32'd0;
        assign tid_ok  = (tids[g] == 8'd0) || (tids[g] == pid8);
        assign zf      = (zsels[g] > ZLIM) ? 2'b01 : zone_field(zone_reg, zsels[g]);
        assign cand[g] = tw.valid && addr_ok && tid_ok && !(user && zf == 2'b00);
    end

    always_comb begin
        hit     = |cand;
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_idx = i[IDX_W-1:0];
            end
        end
    end

    // R5: a reported hit always points at a valid entry
    a_r5_hit_is_valid: assert property (@(posedge clk) disable iff (rst)
        hit |-> tags[hit_idx][6]);

endmodule

// File: rtl/tlb_search_seq.sv
module tlb_search_seq
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      vaddr_in,
    input  logic             user_in,
    input  logic             eng_hit,
    input  logic [IDX_W-1:0] eng_idx,
    output logic             busy,
    output logic [31:0]      look_vaddr,
    output logic             look_user,
    output logic             done,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx
);

    srch_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SR_IDLE;
            look_vaddr <= '0;
            look_user  <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
        end else begin
            unique case (state_q)
                SR_IDLE: begin
                    if (start) begin
                        look_vaddr <= vaddr_in & EPN_MASK;
                        look_user  <= user_in;
                        state_q    <= SR_EVAL;
                    end
                end
                SR_EVAL: begin
                    res_hit <= eng_hit;
                    res_idx <= eng_idx;
                    state_q <= SR_COMMIT;
                end
                SR_COMMIT: state_q <= SR_IDLE;
                default:   state_q <= SR_IDLE;
            endcase
        end
    end

    assign busy = (state_q != SR_IDLE);
    assign done = (state_q == SR_COMMIT);

    // R8: busy rises for exactly two cycles per search
    a_r8_busy_second_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);
    a_r8_busy_ends: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
    import tlb_mgmt_pkg::*;
#(
    parameter int ENTRIES    = 16,
    parameter int ZONE_LIMIT = 7
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  cfg_mmu_level,
    input  logic [1:0]  cfg_access,
    input  logic        user_mode,
    input  logic [2:0]  reg_num,
    input  logic [31:0] reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [31:0] reg_rdata,
    output logic        busy
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [31:0] index_q, pid_q, zone_q;

    logic             regs_on, acc_ok, wr_fire, rd_fire;
    logic             rd_allowed, ctl_wr_allowed;
    logic             we_lo, we_hi, srch_start;
    logic [IDX_W-1:0] sel;
    logic [31:0]      sel_lo, sel_hi;
    logic [7:0]       sel_tid;
    logic [31:0]      tags  [ENTRIES];
    logic [3:0]       zsels [ENTRIES];
    logic [7:0]       tids  [ENTRIES];
    logic             eng_hit, srch_done, srch_hit, look_user;
    logic [IDX_W-1:0] eng_idx, srch_idx;
    logic [31:0]      look_vaddr;

    assign regs_on        = (cfg_mmu_level >= 2'(MMU_FULL_LEVEL)) && (cfg_access != 2'd0);
    assign acc_ok         = regs_on && !busy;
    assign wr_fire        = reg_we && acc_ok;
    assign rd_fire        = reg_re && !reg_we && acc_ok;
    assign rd_allowed     = cfg_access[0];
    assign ctl_wr_allowed = cfg_access[1];
    assign sel            = index_q[IDX_W-1:0];

    assign we_lo      = wr_fire && (reg_num == RN_LO);
    assign we_hi      = wr_fire && (reg_num == RN_HI);
    assign srch_start = wr_fire && (reg_num == RN_SEARCH) && ctl_wr_allowed;

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .sel     (sel),
        .we_lo   (we_lo),
        .we_hi   (we_hi),
        .wdata   (reg_wdata),
        .tid_in  (pid_q[7:0]),
        .sel_lo  (sel_lo),
        .sel_hi  (sel_hi),
        .sel_tid (sel_tid),
        .tags_o  (tags),
        .zsels_o (zsels),
        .tids_o  (tids)
    );

    tlb_match_engine #(.ENTRIES(ENTRIES), .ZONE_LIMIT(ZONE_LIMIT), .IDX_W(IDX_W)) u_match (
        .clk      (clk),
        .rst      (rst),
        .vaddr    (look_vaddr),
        .user     (look_user),
        .pid8     (pid_q[7:0]),
        .zone_reg (zone_q),
        .tags     (tags),
        .zsels    (zsels),
        .tids     (tids),
        .hit      (eng_hit),
        .hit_idx  (eng_idx)
    );

    tlb_search_seq #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (srch_start),
        .vaddr_in   (reg_wdata),
        .user_in    (user_mode),
        .eng_hit    (eng_hit),
        .eng_idx    (eng_idx),
        .busy       (busy),
        .look_vaddr (look_vaddr),
        .look_user  (look_user),
        .done       (srch_done),
        .res_hit    (srch_hit),
        .res_idx    (srch_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            pid_q   <= '0;
            zone_q  <= '0;
        end else begin
            if (srch_done) begin
                index_q <= srch_hit ? {{(32-IDX_W){1'b0}}, srch_idx}
                                    : (index_q | 32'h8000_0000);
            end else if (wr_fire && reg_num == RN_INDEX) begin
                index_q <= reg_wdata;
            end

            if (wr_fire && reg_num == RN_PID && ctl_wr_allowed) begin
                if (reg_wdata != pid_q) begin
                    pid_q <= reg_wdata;
                end
            end else if (rd_fire && reg_num == RN_HI && rd_allowed) begin
                pid_q <= {24'd0, sel_tid};
            end

            if (wr_fire && reg_num == RN_ZONE && ctl_wr_allowed) begin
                zone_q <= reg_wdata;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (acc_ok) begin
            unique case (reg_num)
                RN_INDEX: reg_rdata = index_q;
                RN_LO:    reg_rdata = rd_allowed ? sel_lo : 32'd0;
                RN_HI:    reg_rdata = rd_allowed ? sel_hi : 32'd0;
                RN_PID:   reg_rdata = rd_allowed ? pid_q  : 32'd0;
                RN_ZONE:  reg_rdata = rd_allowed ? zone_q : 32'd0;
                default:  reg_rdata = '0;
            endcase
        end
    end

    // R7: a miss leaves the flag bit set
    a_r7_miss_flag: assert property (@(posedge clk) disable iff (rst)
        (srch_done && !srch_hit) |=> index_q[31]);
    // R5: a hit loads the entry number
    a_r5_hit_loads_index: assert property (@(posedge clk) disable iff (rst)
        (srch_done && srch_hit) |=> (index_q == {{(32-IDX_W){1'b0}}, $past(srch_idx)}));
    // R9: with the registers disabled a write changes no register
    a_r9_off_no_write: assert property (@(posedge clk) disable iff (rst)
        (!regs_on && !busy && reg_we) |=>
            ($stable(index_q) && $stable(pid_q) && $stable(zone_q)));

endmodule

// File: tb/test_tlb_mgmt_regs.sv
module test_tlb_mgmt_regs;

    localparam int N    = 16;
    localparam int ZLIM = 7;
    localparam logic [2:0] R_IDX = 3'd0, R_LO = 3'd1, R_HI = 3'd2,
                           R_PID = 3'd3, R_ZONE = 3'd4, R_SRCH = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mmu_level = 2'd2;
    logic [1:0]  cfg_access = 2'd3;
    logic        user_mode = 1'b0;
    logic [2:0]  reg_num = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        busy;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] m_tag [N];
    logic [31:0] m_data[N];
    logic [7:0]  m_tid [N];
    logic [31:0] m_pid, m_zone, m_index;

    always #5 clk = ~clk;

    tlb_mgmt_regs #(.ENTRIES(N), .ZONE_LIMIT(ZLIM)) i_tlb_mgmt_regs (
        .clk(clk), .rst(rst), .cfg_mmu_level(cfg_mmu_level), .cfg_access(cfg_access),
        .user_mode(user_mode), .reg_num(reg_num), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .busy(busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] num, input logic [31:0] val);
        @(negedge clk);
        reg_num = num; reg_wdata = val; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] num, output logic [31:0] val);
        @(negedge clk);
        reg_num = num; reg_re = 1'b1;
        #2 val = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic put_entry(input int idx, input logic [31:0] lo, input logic [31:0] hi);
        wr(R_IDX, 32'(idx)); m_index = 32'(idx);
        wr(R_LO, lo);        m_data[idx] = lo;
        wr(R_HI, hi);        m_tag[idx] = hi; m_tid[idx] = m_pid[7:0];
    endtask

    task automatic set_pid(input logic [31:0] v);
        wr(R_PID, v); m_pid = v;
    endtask

    task automatic set_zone(input logic [31:0] v);
        wr(R_ZONE, v); m_zone = v;
    endtask

    function automatic logic [1:0] model_zone(input logic [3:0] z);
        if (int'(z) > ZLIM) return 2'b01;
        return m_zone[31 - 2*int'(z) -: 2];
    endfunction

    function automatic int model_search(input logic [31:0] va, input logic usr);
        for (int i = 0; i < N; i++) begin
            logic [31:0] msk;
            if (!m_tag[i][6]) continue;
            msk = ~((32'd1 << (10 + 2*int'(m_tag[i][9:7]))) - 32'd1);
            if (((va & 32'hFFFF_FC00) & msk) != (m_tag[i] & msk)) continue;
            if (m_tid[i] != 8'd0 && m_tid[i] != m_pid[7:0]) continue;
            if (usr && model_zone(m_data[i][7:4]) == 2'b00) continue;
            return i;
        end
        return -1;
    endfunction

    task automatic do_search(input logic [31:0] va, input logic usr, input string req);
        int exp_idx;
        logic [31:0] got;
        user_mode = usr;
        wr(R_SRCH, va);
        chk({req, " busy cycle 1 (R8)"}, 32'(busy), 32'd1);
        @(negedge clk);
        chk({req, " busy cycle 2 (R8)"}, 32'(busy), 32'd1);
        @(negedge clk);
        chk({req, " busy clear (R8)"}, 32'(busy), 32'd0);
        exp_idx = model_search(va, usr);
        m_index = (exp_idx >= 0) ? 32'(exp_idx) : (m_index | 32'h8000_0000);
        rd(R_IDX, got);
        chk({req, " index after search"}, got, m_index);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        process::self().srandom(32'd1234);
        for (int i = 0; i < N; i++) begin m_tag[i] = 0; m_data[i] = 0; m_tid[i] = 0; end
        m_pid = 0; m_zone = 0; m_index = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(R_IDX, v);  chk("R1 index", v, 32'd0);
        rd(R_PID, v);  chk("R1 pid", v, 32'd0);
        rd(R_ZONE, v); chk("R1 zone", v, 32'd0);
        rd(R_LO, v);   chk("R1 lo word", v, 32'd0);
        rd(R_HI, v);   chk("R1 hi word", v, 32'd0);
        do_search(32'h1234_5678, 1'b0, "R1 R7 miss on empty table");
        wr(R_IDX, 32'd0); m_index = 0;

        // R2: word readback through the index
        put_entry(3, 32'hA5A5_0F30, 32'h0040_0240);
        wr(R_IDX, 32'd3);
        rd(R_LO, v); chk("R2 lo readback", v, 32'hA5A5_0F30);
        rd(R_HI, v); chk("R2 hi readback", v, 32'h0040_0240);
        wr(R_IDX, 32'd19); m_index = 19;   // low bits select entry 3
        rd(R_LO, v); chk("R2 low index bits select", v, 32'hA5A5_0F30);

        // R3 / R4: translation ID capture and reload
        set_pid(32'h0000_015A);
        put_entry(4, 32'h0000_0000, 32'h0100_0040);
        set_pid(32'h0000_0011);
        rd(R_LO, v);
        rd(R_PID, v); chk("R4 lo read keeps pid", v, 32'h11);
        rd(R_HI, v);  m_pid = 32'h5A;
        rd(R_PID, v); chk("R3 R4 hi read loads tid", v, 32'h5A);
        set_pid(32'h0);

        // R5: lowest index wins
        put_entry(6, 32'h0, 32'h2000_0040);
        put_entry(2, 32'h0, 32'h2000_0040);
        do_search(32'h2000_0123, 1'b0, "R5 priority");
        chk("R5 priority picks 2", m_index, 32'd2);
        // R5: 16 MB page ignores address bits below 24
        put_entry(7, 32'h0, 32'h3300_03C0);
        do_search(32'h33AB_CDEF, 1'b0, "R5 large page");
        // R5: foreign translation ID filtered
        set_pid(32'h9);
        put_entry(8, 32'h0, 32'h4400_0040);
        set_pid(32'h3);
        do_search(32'h4400_0000, 1'b0, "R5 tid mismatch");
        set_pid(32'h9);
        do_search(32'h4400_0000, 1'b0, "R5 tid match");

        // R6: zone rule
        set_zone(32'h0);
        put_entry(9, 32'h0000_0020, 32'h5500_0040);
        do_search(32'h5500_0000, 1'b1, "R6 zone 0 user rejects");
        do_search(32'h5500_0000, 1'b0, "R6 zone 0 supervisor hits");
        set_zone(32'h0C00_0000);
        do_search(32'h5500_0000, 1'b1, "R6 zone 2 field 3 hits");
        set_zone(32'h0);
        put_entry(10, 32'h0000_00C0, 32'h6600_0040);
        do_search(32'h6600_0000, 1'b1, "R6 zone above limit");

        // R8: accesses during busy
        user_mode = 1'b0;
        wr(R_SRCH, 32'h6600_0000);
        reg_num = R_IDX; reg_wdata = 32'h55; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_re = 1'b1;
        #2 chk("R8 read during busy", reg_rdata, 32'd0);
        @(negedge clk);
        reg_re = 1'b0;
        m_index = 32'(model_search(32'h6600_0000, 1'b0));
        rd(R_IDX, v); chk("R8 write during busy ignored", v, m_index);

        // Random mix against the model
        for (int it = 0; it < 300; it++) begin
            int op = $urandom_range(0, 9);
            if (op < 4) begin
                logic [31:0] hi, lo;
                hi = ({29'($urandom_range(0, 7)), 20'h0} | ($urandom & 32'h000F_FC00))
                     | (32'($urandom_range(0, 7)) << 7) | (($urandom_range(0, 3) != 0) ? 32'h40 : 32'h0);
                lo = $urandom;
                put_entry($urandom_range(0, N-1), lo, hi);
            end else if (op == 4) begin
                set_pid(32'($urandom_range(0, 2)));
            end else if (op == 5) begin
                set_zone($urandom);
            end else begin
                do_search({29'($urandom_range(0, 7)), 20'h0} | ($urandom & 32'h000F_FFFF),
                          1'($urandom_range(0, 1)), "R5 R6 R7 random search");
            end
        end

        // R9: registers disabled
        wr(R_IDX, 32'd5); m_index = 5;
        cfg_mmu_level = 2'd1;
        rd(R_IDX, v); chk("R9 low level reads 0", v, 32'd0);
        wr(R_PID, 32'h77); wr(R_IDX, 32'd9); wr(R_ZONE, 32'hFFFF);
        cfg_mmu_level = 2'd2; cfg_access = 2'd0;
        rd(R_IDX, v); chk("R9 access 0 reads 0", v, 32'd0);
        wr(R_IDX, 32'd11);
        cfg_access = 2'd3;
        rd(R_IDX, v);  chk("R9 index untouched", v, m_index);
        rd(R_PID, v);  chk("R9 pid untouched", v, m_pid);
        rd(R_ZONE, v); chk("R9 zone untouched", v, m_zone);

        // R10: control writes blocked with bit 1 clear
        cfg_access = 2'd1;
        wr(R_PID, m_pid ^ 32'h33); wr(R_ZONE, ~m_zone);
        wr(R_SRCH, 32'h0);
        chk("R10 search not started", 32'(busy), 32'd0);
        wr(R_IDX, 32'd12); m_index = 12;
        wr(R_LO, 32'hCAFE_0000); m_data[12] = 32'hCAFE_0000;
        rd(R_LO, v);  chk("R10 lo write allowed", v, 32'hCAFE_0000);
        rd(R_PID, v); chk("R10 pid write ignored", v, m_pid);
        rd(R_ZONE, v); chk("R10 zone write ignored", v, m_zone);
        rd(R_IDX, v); chk("R10 index write allowed", v, 32'd12);

        // R11: reads blocked with bit 0 clear
        cfg_access = 2'd2;
        set_pid(32'h0000_00EE);
        rd(R_LO, v);   chk("R11 lo reads 0", v, 32'd0);
        rd(R_HI, v);   chk("R11 hi reads 0", v, 32'd0);
        rd(R_ZONE, v); chk("R11 zone reads 0", v, 32'd0);
        rd(R_IDX, v);  chk("R11 index readable", v, 32'd12);
        cfg_access = 2'd3;
        rd(R_PID, v);  chk("R11 hi read no side effect", v, 32'hEE);

        // R12: unassigned numbers
        rd(R_SRCH, v); chk("R12 search reads 0", v, 32'd0);
        wr(3'd6, 32'hDEAD_BEEF); wr(3'd7, 32'h1);
        rd(3'd6, v);   chk("R12 reg 6 reads 0", v, 32'd0);
        rd(R_IDX, v);  chk("R12 index unchanged", v, 32'd12);
        rd(R_PID, v);  chk("R12 pid unchanged", v, 32'hEE);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule